// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block is the transmit half of a packet DMA. The host keeps a ring of descriptors in memory, each sixteen bytes long. It prepares an entry and moves a producer index forward. The engine keeps its own consumer index and works through the ring until that index meets the producer. For each entry it reads the buffer address, the length, the last-segment flag and a destination port. It sends the buffer one byte per beat on a valid/ready byte stream. It then writes the control word back to memory with the done flag set, so the host knows it may reuse the slot.

All memory traffic uses one request/acknowledge port that carries 32-bit words and has a single access outstanding. A small register window holds the ring base and size, the two indices, an index reset and a control word. The control word holds run enable, write-back enable and a busy flag. When enable is cleared, the frame in flight still finishes, and busy then drops. Software can poll busy to confirm a clean stop.

Top module: `tdr_tx_dma`

## Requirements
- R1: After reset the busy flag and the consumer index read 0, and neither `tx_tvalid` nor `mem_req` is asserted.
- R2: The register window has these word addresses: 0 ring base, 1 ring size, 2 producer index, 3 consumer index (read-only), 4 index reset, 5 control. Control bit 0 is run enable, bit 1 is busy (read-only) and bit 6 is write-back enable. Base and size read back as written.
- R3: Descriptor n starts at base + 16·n. Word 0 is the buffer byte address. Word 1 is the control word: length in bits [29:16], last-segment flag in bit 30, done flag in bit 31. Word 3 holds the destination port in bits [26:24].
- R4: Exactly `length` bytes are sent, in ascending address order, from any starting byte alignment. Within a memory word, byte lane 0 (bits [7:0]) is the lowest address.
- R5: `tx_tlast` is high on the final byte of a buffer if and only if that descriptor's last-segment flag is 1.
- R6: `tx_tdest` carries the descriptor's port field on every byte of that buffer.
- R7: With write-back enabled, after the last byte the control word is written back at the same address with bit 31 set and every other bit unchanged.
- R8: The engine processes descriptors while the consumer index differs from the producer index. The consumer index steps by one per descriptor and wraps to 0 when it reaches the ring size.
- R9: A zero-length descriptor sends no bytes, but it is still written back and the index still advances.
- R10: With write-back disabled, descriptors are sent and the index advances, but memory is never written.
- R11: With run enable clear, no new descriptor starts. A frame already in flight completes, the consumer index stops one past it, and busy then reads 0.
- R12: Writing 1 to bit 0 of the index reset register while idle sets the consumer index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (word aligned) |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete; read data valid |
| mem_rdata | input | 32 | Memory read data |
| tx_tdata | output | 8 | Stream byte |
| tx_tvalid | output | 1 | Stream byte valid |
| tx_tready | input | 1 | Stream sink ready |
| tx_tlast | output | 1 | Last byte of a final segment |
| tx_tdest | output | 3 | Destination port of the current buffer |

## Verification
A wrong consumer index shows at once: the next fetch reads the wrong descriptor address, and the bench also sees it as a bad index readback at the next idle point. A wrong byte pointer or remaining count shows within one beat, as a misordered byte, a missing `tx_tlast` or a wrong frame length. A corrupted cached control word surfaces at write-back, where the bench compares the rewritten word against the original with only the done bit added. A stop that ends busy too early or too late shows as a consumer index that is not exactly one past the interrupted frame.

// File: rtl/tdr_pkg.sv
package tdr_pkg;

  localparam int DESC_BYTES = 16;
  localparam int LEN_LSB    = 16;
  localparam int LEN_W      = 14;
  localparam int LS_BIT     = 30;
  localparam int DONE_BIT   = 31;
  localparam int PORT_LSB   = 24;
  localparam int PORT_W     = 3;

  localparam logic [2:0] RA_BASE = 3'd0;
  localparam logic [2:0] RA_SIZE = 3'd1;
  localparam logic [2:0] RA_PROD = 3'd2;
  localparam logic [2:0] RA_CONS = 3'd3;
  localparam logic [2:0] RA_IRST = 3'd4;
  localparam logic [2:0] RA_CTRL = 3'd5;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_BUSY = 1;
  localparam int CTRL_WB   = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC_PTR,
    ST_DESC_CTL,
    ST_DESC_PORT,
    ST_BUF_WORD,
    ST_STREAM,
    ST_WRITEBACK,
    ST_ADVANCE
  } tdr_state_e;

  // Byte address of one word of a ring entry.
  function automatic logic [31:0] entry_word_addr(input logic [31:0] base,
                                                  input logic [31:0] slot,
                                                  input logic [1:0]  word);
    return base + (slot << 4) + {28'd0, word, 2'b00};
  endfunction

  // Next ring slot, wrapping when the ring size is reached.
  function automatic logic [31:0] next_slot(input logic [31:0] slot,
                                            input logic [31:0] size);
    return ((slot + 32'd1) >= size) ? 32'd0 : slot + 32'd1;
  endfunction

  // Byte lane of a little-endian memory word.
  function automatic logic [7:0] lane_byte(input logic [31:0] word,
                                           input logic [1:0]  lane);
    return word[{lane, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/tdr_regfile.sv
module tdr_regfile
  import tdr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic [IDX_W-1:0] cons_idx,
  input  logic             busy,
  output logic [31:0]      ring_base,
  output logic [IDX_W-1:0] ring_size,
  output logic [IDX_W-1:0] prod_idx,
  output logic             run_en,
  output logic             wb_en,
  output logic             idx_clear
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_base <= '0;
      ring_size <= '0;
      prod_idx  <= '0;
      run_en    <= 1'b0;
      wb_en     <= 1'b0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RA_BASE: ring_base <= cfg_wdata;
        RA_SIZE: ring_size <= cfg_wdata[IDX_W-1:0];
        RA_PROD: prod_idx  <= cfg_wdata[IDX_W-1:0];
        RA_CTRL: begin
          run_en <= cfg_wdata[CTRL_RUN];
          wb_en  <= cfg_wdata[CTRL_WB];
        end
        default: ;
      endcase
    end
  end

  // Pulse; the engine honours it only while idle.
  assign idx_clear = cfg_we && (cfg_addr == RA_IRST) && cfg_wdata[0];

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      RA_BASE: cfg_rdata = ring_base;
      RA_SIZE: cfg_rdata = 32'(ring_size);
      RA_PROD: cfg_rdata = 32'(prod_idx);
      RA_CONS: cfg_rdata = 32'(cons_idx);
      RA_CTRL: begin
        cfg_rdata[CTRL_RUN]  = run_en;
        cfg_rdata[CTRL_BUSY] = busy;
        cfg_rdata[CTRL_WB]   = wb_en;
      end
      default: cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/tdr_engine.sv
module tdr_engine
  import tdr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       ring_base,
  input  logic [IDX_W-1:0]  ring_size,
  input  logic [IDX_W-1:0]  prod_idx,
  input  logic              run_en,
  input  logic              wb_en,
  input  logic              idx_clear,
  output logic [IDX_W-1:0]  cons_idx,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [7:0]        tx_tdata,
  output logic              tx_tvalid,
  input  logic              tx_tready,
  output logic              tx_tlast,
  output logic [PORT_W-1:0] tx_tdest
);

  tdr_state_e        state;
  logic [31:0]       buf_ptr;
  logic [31:0]       ctl_word;
  logic [31:0]       buf_word;
  logic [LEN_W-1:0]  remaining;
  logic [PORT_W-1:0] dest;

  // Named internal events
  logic       start_entry;
  logic       byte_fire;
  logic       final_byte;
  logic       word_end;
  tdr_state_e after_buf;

  assign start_entry = (state == ST_IDLE) && run_en && !idx_clear && (cons_idx != prod_idx);
  assign byte_fire   = (state == ST_STREAM) && tx_tready;
  assign final_byte  = (remaining == LEN_W'(1));
  assign word_end    = (buf_ptr[1:0] == 2'b11);
  assign after_buf   = wb_en ? ST_WRITEBACK : ST_ADVANCE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cons_idx  <= '0;
      buf_ptr   <= '0;
      ctl_word  <= '0;
      buf_word  <= '0;
      remaining <= '0;
      dest      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (idx_clear) cons_idx <= '0;
          else if (start_entry) state <= ST_DESC_PTR;
        end
        ST_DESC_PTR: if (mem_ack) begin
          buf_ptr <= mem_rdata;
          state   <= ST_DESC_CTL;
        end
        ST_DESC_CTL: if (mem_ack) begin
          ctl_word  <= mem_rdata;
          remaining <= mem_rdata[LEN_LSB +: LEN_W];
          state     <= ST_DESC_PORT;
        end
        ST_DESC_PORT: if (mem_ack) begin
          dest  <= mem_rdata[PORT_LSB +: PORT_W];
          state <= (remaining == '0) ? after_buf : ST_BUF_WORD;
        end
        ST_BUF_WORD: if (mem_ack) begin
          buf_word <= mem_rdata;
          state    <= ST_STREAM;
        end
        ST_STREAM: if (byte_fire) begin
          buf_ptr   <= buf_ptr + 32'd1;
          remaining <= remaining - LEN_W'(1);
          if (final_byte)    state <= after_buf;
          else if (word_end) state <= ST_BUF_WORD;
        end
        ST_WRITEBACK: if (mem_ack) state <= ST_ADVANCE;
        ST_ADVANCE: begin
          cons_idx <= IDX_W'(next_slot(32'(cons_idx), 32'(ring_size)));
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_wdata = '0;
    mem_addr  = '0;
    case (state)
      ST_DESC_PTR:  mem_addr = entry_word_addr(ring_base, 32'(cons_idx), 2'd0);
      ST_DESC_CTL:  mem_addr = entry_word_addr(ring_base, 32'(cons_idx), 2'd1);
      ST_DESC_PORT: mem_addr = entry_word_addr(ring_base, 32'(cons_idx), 2'd3);
      ST_BUF_WORD:  mem_addr = {buf_ptr[31:2], 2'b00};
      ST_WRITEBACK: begin
        mem_addr  = entry_word_addr(ring_base, 32'(cons_idx), 2'd1);
        mem_we    = 1'b1;
        mem_wdata = ctl_word | (32'd1 << DONE_BIT);
      end
      default: mem_req = 1'b0;
    endcase
  end

  assign tx_tvalid = (state == ST_STREAM);
  assign tx_tdata  = tx_tvalid ? lane_byte(buf_word, buf_ptr[1:0]) : 8'h00;
  assign tx_tlast  = tx_tvalid && final_byte && ctl_word[LS_BIT];
  assign tx_tdest  = dest;

  // R4: a stalled byte holds its value
  a_r4_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tvalid && !tx_tready |=> tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast));

  // R3: memory request is held stable until acknowledged
  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R7: every memory write marks the descriptor done
  a_r7_write_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[DONE_BIT]);

  // R5: a final byte ends the buffer's stream
  a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tvalid && tx_tready && tx_tlast |=> !tx_tvalid);

  // R8: the consumer index only steps by one or returns to zero
  a_r8_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cons_idx) |-> (cons_idx == '0) || (cons_idx == $past(cons_idx) + 1'b1));

  // R11: work only begins while enabled
  a_r11_start_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(run_en));

  // R10: no memory write while write-back is off at the end of a buffer
  a_r10_no_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STREAM) && byte_fire && final_byte && !wb_en |=> !mem_we);

endmodule

// File: rtl/tdr_tx_dma.sv
module tdr_tx_dma
  import tdr_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_addr,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic [7:0]  tx_tdata,
  output logic        tx_tvalid,
  input  logic        tx_tready,
  output logic        tx_tlast,
  output logic [2:0]  tx_tdest
);

  logic [31:0]      ring_base;
  logic [IDX_W-1:0] ring_size;
  logic [IDX_W-1:0] prod_idx;
  logic [IDX_W-1:0] cons_idx;
  logic             run_en;
  logic             wb_en;
  logic             idx_clear;
  logic             busy;

  tdr_regfile #(.IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cons_idx  (cons_idx),
    .busy      (busy),
    .ring_base (ring_base),
    .ring_size (ring_size),
    .prod_idx  (prod_idx),
    .run_en    (run_en),
    .wb_en     (wb_en),
    .idx_clear (idx_clear)
  );

  tdr_engine #(.IDX_W(IDX_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_base (ring_base),
    .ring_size (ring_size),
    .prod_idx  (prod_idx),
    .run_en    (run_en),
    .wb_en     (wb_en),
    .idx_clear (idx_clear),
    .cons_idx  (cons_idx),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .tx_tdata  (tx_tdata),
    .tx_tvalid (tx_tvalid),
    .tx_tready (tx_tready),
    .tx_tlast  (tx_tlast),
    .tx_tdest  (tx_tdest)
  );

  // R1: idle engine drives no traffic
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !tx_tvalid && !mem_req);

endmodule

// File: tb/tb_tdr_tx_dma.sv
`timescale 1ns/100ps
module tb_tdr_tx_dma;

  localparam int RING = 4;
  localparam logic [31:0] BASE = 32'h100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  tx_tdata;
  logic        tx_tvalid, tx_tready, tx_tlast;
  logic [2:0]  tx_tdest;

  tdr_tx_dma dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_tdata(tx_tdata),
    .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tlast(tx_tlast),
    .tx_tdest(tx_tdest)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int writes_seen = 0;

  logic [31:0] mem [0:1023];
  logic [7:0]  exp_d[$];
  logic        exp_l[$];
  logic [2:0]  exp_p[$];
  logic [7:0]  got_d[$];
  logic        got_l[$];
  logic [2:0]  got_p[$];
  logic [31:0] saved_ctl [0:RING-1];

  function automatic int ring_next(int i);
    return (i == RING - 1) ? 0 : i + 1;
  endfunction

  function automatic logic [31:0] slot_addr(int i);
    return BASE + 32'(i * 16);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_byte(input logic [31:0] a, input logic [7:0] b);
    mem[a[11:2]][a[1:0]*8 +: 8] = b;
  endtask

  // Memory responder
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req && ($urandom_range(0, 2) != 0)) begin
        mem_ack = 1'b1;
        mem_rdata = mem[mem_addr[11:2]];
        if (mem_we) begin
          mem[mem_addr[11:2]] = mem_wdata;
          writes_seen++;
        end
      end
    end
  end

  // Stream sink: decides ready before the edge and records the transfer
  initial begin
    tx_tready = 1'b0;
    forever begin
      @(negedge clk);
      tx_tready = ($urandom_range(0, 3) != 0);
      if (tx_tvalid && tx_tready) begin
        got_d.push_back(tx_tdata);
        got_l.push_back(tx_tlast);
        got_p.push_back(tx_tdest);
      end
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #0.3;
    d = cfg_rdata;
  endtask

  // Build one descriptor and append its expected bytes
  task automatic make_desc(input int slot, input int len, input int off,
                           input bit ls, input logic [2:0] port);
    logic [31:0] buf_a;
    buf_a = 32'h400 + 32'(slot * 64 + off);
    mem[slot_addr(slot) >> 2]       = buf_a;
    saved_ctl[slot]                  = (32'(len) << 16) | (32'(ls) << 30);
    mem[(slot_addr(slot) >> 2) + 1] = saved_ctl[slot];
    mem[(slot_addr(slot) >> 2) + 2] = 32'h0;
    mem[(slot_addr(slot) >> 2) + 3] = {5'd0, port, 24'h00ab12};
    for (int k = 0; k < len; k++) begin
      logic [7:0] b;
      b = 8'($urandom);
      set_byte(buf_a + 32'(k), b);
      exp_d.push_back(b);
      exp_l.push_back(ls && (k == len - 1));
      exp_p.push_back(port);
    end
  endtask

  task automatic wait_done(input int target, input string req);
    logic [31:0] ci, ct;
    int n = 0;
    do begin
      @(negedge clk);
      #0.2;
      reg_rd(3'd3, ci);
      reg_rd(3'd5, ct);
      n++;
    end while (!(ci == 32'(target) && !ct[1]) && n < 4000);
    check(ci == 32'(target) && !ct[1], req, ci, 32'(target));
  endtask

  task automatic check_stream(input string req);
    int bad = 0;
    if (got_d.size() != exp_d.size()) bad = 1;
    else
      for (int k = 0; k < exp_d.size(); k++)
        if (got_d[k] !== exp_d[k] || got_l[k] !== exp_l[k] || got_p[k] !== exp_p[k]) begin
          if (bad == 0)
            $display("FAIL %s byte %0d actual=%h/%b/%0d expected=%h/%b/%0d", req, k,
                     got_d[k], got_l[k], got_p[k], exp_d[k], exp_l[k], exp_p[k]);
          bad++;
        end
    checks++;
    if (bad != 0) begin
      errors++;
      if (got_d.size() != exp_d.size())
        $display("FAIL %s count actual=%0d expected=%0d", req, got_d.size(), exp_d.size());
    end
    exp_d.delete(); exp_l.delete(); exp_p.delete();
    got_d.delete(); got_l.delete(); got_p.delete();
  endtask

  task automatic check_wb(input int slot, input bit done, input string req);
    logic [31:0] e;
    e = done ? (saved_ctl[slot] | 32'h8000_0000) : saved_ctl[slot];
    check(mem[(slot_addr(slot) >> 2) + 1] == e, req, mem[(slot_addr(slot) >> 2) + 1], e);
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cur;
    int w0;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(!tx_tvalid && !mem_req, "R1 outputs", {tx_tvalid, mem_req}, 0);
    reg_rd(3'd3, v); check(v == 0, "R1 consumer index", v, 0);
    reg_rd(3'd5, v); check(v[1] == 1'b0, "R1 busy", v, 0);

    // R2 register map
    reg_wr(3'd0, BASE);
    reg_wr(3'd1, RING);
    reg_rd(3'd0, v); check(v == BASE, "R2 base", v, BASE);
    reg_rd(3'd1, v); check(v == RING, "R2 size", v, RING);
    reg_wr(3'd5, 32'h41);
    reg_rd(3'd5, v); check(v[6] && v[0], "R2 control", v, 32'h41);

    // R3 R4 R5 R6 R7: three aligned and unaligned buffers
    make_desc(0, 13, 0, 1, 3'd5);
    make_desc(1, 7, 3, 1, 3'd2);
    make_desc(2, 1, 1, 1, 3'd7);
    reg_wr(3'd2, 3);
    wait_done(3, "R8 run to producer");
    check_stream("R4 R5 R6 stream");
    for (int s = 0; s < 3; s++) check_wb(s, 1, "R7 write-back");

    // R5 no last flag, R8 wrap
    make_desc(3, 6, 2, 0, 3'd1);
    make_desc(0, 9, 1, 1, 3'd1);
    reg_wr(3'd2, 1);
    wait_done(1, "R8 wrap");
    check_stream("R5 segment without last");
    check_wb(3, 1, "R7 write-back seg");

    // R9 zero length
    make_desc(1, 0, 0, 1, 3'd4);
    reg_wr(3'd2, 2);
    wait_done(2, "R9 index advance");
    check(got_d.size() == 0, "R9 no bytes", got_d.size(), 0);
    check_wb(1, 1, "R9 write-back");
    check_stream("R9 stream");

    // R10 write-back disabled
    reg_wr(3'd5, 32'h01);
    w0 = writes_seen;
    make_desc(2, 10, 2, 1, 3'd6);
    reg_wr(3'd2, 3);
    wait_done(3, "R10 index advance");
    check_stream("R10 stream");
    check(writes_seen == w0, "R10 no memory write", writes_seen, w0);
    check_wb(2, 0, "R10 word unchanged");
    reg_wr(3'd5, 32'h41);

    // Random rounds
    cur = 3;
    for (int r = 0; r < 8; r++) begin
      int n;
      int p;
      n = $urandom_range(1, 3);
      p = cur;
      for (int k = 0; k < n; k++) begin
        make_desc(p, $urandom_range(0, 40), $urandom_range(0, 3), 1'($urandom),
                  3'($urandom));
        p = ring_next(p);
      end
      reg_wr(3'd2, p);
      wait_done(p, "R8 random round");
      check_stream("R4 random stream");
      for (int k = 0, q = cur; k < n; k++, q = ring_next(q)) check_wb(q, 1, "R7 random");
      cur = p;
    end

    // R11 stop with a frame in flight
    begin
      int p;
      int first_len;
      first_len = 40;
      p = cur;
      for (int k = 0; k < 3; k++) begin
        make_desc(p, 40, k, 1, 3'd3);
        p = ring_next(p);
      end
      reg_wr(3'd2, p);
      while (!tx_tvalid) @(negedge clk);
      reg_wr(3'd5, 32'h40);
      wait_done(ring_next(cur), "R11 stops after in-flight frame");
      check(got_d.size() == first_len, "R11 in-flight frame complete",
            got_d.size(), first_len);
      repeat (40) @(negedge clk);
      check(got_d.size() == first_len && !mem_req, "R11 no new start",
            got_d.size(), first_len);
      reg_wr(3'd5, 32'h41);
      wait_done(p, "R11 resume");
      check_stream("R11 full stream");
      cur = p;
    end

    // R12 index reset while idle
    reg_wr(3'd5, 32'h40);
    reg_wr(3'd2, 0);
    reg_wr(3'd4, 1);
    reg_rd(3'd3, v); check(v == 0, "R12 index cleared", v, 0);
    reg_wr(3'd5, 32'h41);
    begin
      bit quiet = 1;
      repeat (30) begin
        @(negedge clk);
        if (mem_req || tx_tvalid) quiet = 0;
      end
      check(quiet, "R12 no work when indices equal", {31'd0, quiet}, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule